// File: doc/BRIEF.md
# Dual-Path Bus Register

This block is an 18-bit register that sits between two buses, called A and B. It carries data in both directions, and the two directions are controlled separately. For each direction, the A-to-B path and the B-to-A path, one storage word can work in three ways:
- It passes the incoming word straight through while its latch enable is high.
- It holds the word while its latch enable is low.
- It captures a new word on a rising edge of its own data clock, when its active-low clock enable is asserted.

Each direction also has an active-low output enable. Instead of a tri-state pin, the block gives a drive flag next to each output word.

All control and data pins are treated as asynchronous to the fast system clock `clk`. A chain of synchronizer flops brings them into that clock domain. Rising edges of a data clock are found by comparing the current synchronized sample with the one before it. A synchronous active-high reset clears both storage words and drops both drive flags.

Top module: `dual_path_bus_reg`

## Requirements
- R1: While a direction's latch enable is high, its storage word, and so its output word, copies that direction's input word. This holds whatever the data clock and clock enable are doing.
- R2: While the latch enable is low and the data clock does not rise, the storage word keeps its value and changes on the input word are ignored.
- R3: While the latch enable is low and the clock enable is low, a low-to-high transition of the data clock loads the input word into storage.
- R4: While the clock enable is high, rising data-clock edges do not change the storage word.
- R5: The drive flag is 1 when the output enable is low and 0 when it is high. The output word always shows the storage word, whether the flag is 0 or 1.
- R6: The two directions share no state. Activity on the B-to-A controls and data never changes the A-to-B storage word, and the reverse is also true.
- R7: If the latch enable falls while the data clock is high, storage keeps the word that was passing through. A later falling edge of the data clock does not load a new word.
- R8: When `rst` is high at a `clk` edge, both storage words become 0 and both drive flags become 0.
- R9: A change on any pin reaches the outputs on the SYNC_STAGES+1-th rising `clk` edge after the change. This is the 3rd edge at the default SYNC_STAGES of 2.
- R10: Each drive flag depends only on its own direction's output enable. Both flags being 1 at once is a bus conflict, and the checker flags it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Word arriving from bus A |
| b_in | input | W | Word arriving from bus B |
| ab_le | input | 1 | A-to-B latch enable, high = pass through |
| ab_dclk | input | 1 | A-to-B data clock, capture on rising edge |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, high = pass through |
| ba_dclk | input | 1 | B-to-A data clock, capture on rising edge |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| b_out | output | W | A-to-B storage word presented toward bus B |
| b_drive | output | 1 | 1 when b_out should drive bus B |
| a_out | output | W | B-to-A storage word presented toward bus A |
| a_drive | output | 1 | 1 when a_out should drive bus A |

## Verification
The bench builds the block with its default W of 18 and SYNC_STAGES of 2. Because the word is 18 bits wide, patterns with the top bit set, all-ones and all-zeros words can be told apart from one another. The two-stage chain fixes the pin-to-output delay at three edges, and the bench probes that delay one edge early and on time. One table of sixteen vectors covers every mix of latch enable, clock enable, clock pulse and output enable. It is run once for each direction, and the bench then checks that the opposite direction's word was left untouched. Directed steps cover a latch closing while the data clock is high, reset in the middle of operation, and drive flags that must stay apart.

// File: rtl/dpbr_pkg.sv
package dpbr_pkg;

  // Control pins of one direction, after synchronization.
  typedef struct packed {
    logic le;     // 1 = pass through
    logic dclk;   // data clock level
    logic ce_n;   // clock enable, active low
    logic oe_n;   // output enable, active low
  } dir_ctl_t;

  localparam int CTL_BITS = $bits(dir_ctl_t);
  localparam int NUM_DIRS = 2;
  localparam int DIR_AB   = 0;
  localparam int DIR_BA   = 1;

endpackage

// File: rtl/dpbr_sync.sv
module dpbr_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  // The chain carries no reset, so it flushes while rst is held.
  always_ff @(posedge clk) begin
    stg[0] <= d;
    for (int i = 1; i < STAGES; i++) begin
      stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/dpbr_lane.sv
module dpbr_lane
  import dpbr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  dir_ctl_t     ctl,
  output logic [W-1:0] dout,
  output logic         drive,
  output logic         edge_seen
);

  logic         dclk_prev;
  logic [W-1:0] store_q;
  logic         drive_q;

  // Priority: pass-through first, then an enabled rising edge, else hold.
  function automatic logic [W-1:0] next_word(
    input logic         le,
    input logic         rise,
    input logic         ce_n,
    input logic [W-1:0] cur,
    input logic [W-1:0] d
  );
    if (le)
      return d;
    else if (rise && !ce_n)
      return d;
    else
      return cur;
  endfunction

  assign edge_seen = ctl.dclk & ~dclk_prev;

  // dclk_prev keeps tracking during reset, so a clock that is already high
  // does not look like a rising edge once reset is released.
  always_ff @(posedge clk) begin
    dclk_prev <= ctl.dclk;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
      drive_q <= 1'b0;
    end else begin
      store_q <= next_word(ctl.le, edge_seen, ctl.ce_n, store_q, din);
      drive_q <= ~ctl.oe_n;
    end
  end

  assign dout  = store_q;
  assign drive = drive_q;

endmodule

// File: rtl/dual_path_bus_reg.sv
module dual_path_bus_reg
  import dpbr_pkg::*;
#(
  parameter int W           = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_le,
  input  logic         ab_dclk,
  input  logic         ab_ce_n,
  input  logic         ab_oe_n,
  input  logic         ba_le,
  input  logic         ba_dclk,
  input  logic         ba_ce_n,
  input  logic         ba_oe_n,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  output logic [W-1:0] a_out,
  output logic         a_drive
);

  localparam int RAW_BITS = NUM_DIRS * (CTL_BITS + W);

  logic [RAW_BITS-1:0] raw_pins;
  logic [RAW_BITS-1:0] raw_sync;

  dir_ctl_t     ctl_s  [NUM_DIRS];
  logic [W-1:0] din_s  [NUM_DIRS];
  logic [W-1:0] dout_w [NUM_DIRS];
  logic         drv_w  [NUM_DIRS];
  logic         rise_w [NUM_DIRS];

  // Named internal events for the checker.
  logic         ab_le_s, ab_ce_n_s, ab_rise;
  logic         ba_le_s, ba_ce_n_s, ba_rise;
  logic [W-1:0] a_s, b_s;

  assign raw_pins = {ba_le, ba_dclk, ba_ce_n, ba_oe_n,
                     ab_le, ab_dclk, ab_ce_n, ab_oe_n,
                     b_in, a_in};

  dpbr_sync #(.W(RAW_BITS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (raw_pins),
    .q   (raw_sync)
  );

  assign din_s[DIR_AB] = raw_sync[W-1:0];
  assign din_s[DIR_BA] = raw_sync[2*W-1:W];
  assign ctl_s[DIR_AB] = dir_ctl_t'(raw_sync[2*W +: CTL_BITS]);
  assign ctl_s[DIR_BA] = dir_ctl_t'(raw_sync[2*W+CTL_BITS +: CTL_BITS]);

  for (genvar g = 0; g < NUM_DIRS; g++) begin : g_lane
    dpbr_lane #(.W(W)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .din       (din_s[g]),
      .ctl       (ctl_s[g]),
      .dout      (dout_w[g]),
      .drive     (drv_w[g]),
      .edge_seen (rise_w[g])
    );
  end

  assign b_out   = dout_w[DIR_AB];
  assign b_drive = drv_w[DIR_AB];
  assign a_out   = dout_w[DIR_BA];
  assign a_drive = drv_w[DIR_BA];

  assign ab_le_s   = ctl_s[DIR_AB].le;
  assign ab_ce_n_s = ctl_s[DIR_AB].ce_n;
  assign ab_rise   = rise_w[DIR_AB];
  assign ba_le_s   = ctl_s[DIR_BA].le;
  assign ba_ce_n_s = ctl_s[DIR_BA].ce_n;
  assign ba_rise   = rise_w[DIR_BA];
  assign a_s       = din_s[DIR_AB];
  assign b_s       = din_s[DIR_BA];

endmodule

// File: rtl/dpbr_checker.sv
module dpbr_checker #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic         ab_le_s,
  input logic         ab_ce_n_s,
  input logic         ab_rise,
  input logic         ba_le_s,
  input logic         ba_ce_n_s,
  input logic         ba_rise,
  input logic [W-1:0] a_s,
  input logic [W-1:0] b_s,
  input logic [W-1:0] b_out,
  input logic         b_drive,
  input logic [W-1:0] a_out,
  input logic         a_drive
);

  // R1: pass-through copies the synchronized input
  a_r1_ab_pass: assert property (@(posedge clk) disable iff (rst)
    ab_le_s |=> (b_out == $past(a_s)));
  a_r1_ba_pass: assert property (@(posedge clk) disable iff (rst)
    ba_le_s |=> (a_out == $past(b_s)));

  // R2: closed latch, no rising edge -> word stays
  a_r2_ab_hold: assert property (@(posedge clk) disable iff (rst)
    (!ab_le_s && !ab_rise) |=> $stable(b_out));
  a_r2_ba_hold: assert property (@(posedge clk) disable iff (rst)
    (!ba_le_s && !ba_rise) |=> $stable(a_out));

  // R3: enabled rising edge loads the word
  a_r3_ab_capture: assert property (@(posedge clk) disable iff (rst)
    (!ab_le_s && ab_rise && !ab_ce_n_s) |=> (b_out == $past(a_s)));
  a_r3_ba_capture: assert property (@(posedge clk) disable iff (rst)
    (!ba_le_s && ba_rise && !ba_ce_n_s) |=> (a_out == $past(b_s)));

  // R4: disabled clock edge leaves the word
  a_r4_ab_gated: assert property (@(posedge clk) disable iff (rst)
    (!ab_le_s && ab_rise && ab_ce_n_s) |=> $stable(b_out));
  a_r4_ba_gated: assert property (@(posedge clk) disable iff (rst)
    (!ba_le_s && ba_rise && ba_ce_n_s) |=> $stable(a_out));

  // R8: reset empties both words and drops both flags
  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (b_out == '0 && a_out == '0 && !b_drive && !a_drive));

  // R10: the two directions never drive at the same time
  a_r10_no_contention: assert property (@(posedge clk) disable iff (rst)
    !(a_drive && b_drive));

endmodule

bind dual_path_bus_reg dpbr_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ab_le_s   (ab_le_s),
  .ab_ce_n_s (ab_ce_n_s),
  .ab_rise   (ab_rise),
  .ba_le_s   (ba_le_s),
  .ba_ce_n_s (ba_ce_n_s),
  .ba_rise   (ba_rise),
  .a_s       (a_s),
  .b_s       (b_s),
  .b_out     (b_out),
  .b_drive   (b_drive),
  .a_out     (a_out),
  .a_drive   (a_drive)
);

// File: tb/sim_dual_path_bus_reg.sv
`timescale 1ns/1ps
module sim_dual_path_bus_reg;

  localparam int W        = 18;
  localparam int LAT      = 3;       // SYNC_STAGES + 1 (R9)
  localparam int WD_LIMIT = 20000;

  typedef struct packed {
    logic         le;
    logic         ce_n;
    logic         pulse;
    logic         oe_n;
    logic [W-1:0] din;
    logic [W-1:0] exp_q;
    logic         exp_drv;
  } vec_t;

  // Walks every {le, ce_n, pulse, oe_n} mix; expected word follows R1-style rules.
  localparam vec_t TABLE [16] = '{
    '{1'b1, 1'b1, 1'b0, 1'b0, 18'h15A5A, 18'h15A5A, 1'b1},
    '{1'b0, 1'b0, 1'b0, 1'b0, 18'h3FFFF, 18'h15A5A, 1'b1},
    '{1'b0, 1'b0, 1'b1, 1'b0, 18'h0C3C3, 18'h0C3C3, 1'b1},
    '{1'b0, 1'b1, 1'b1, 1'b0, 18'h2AAAA, 18'h0C3C3, 1'b1},
    '{1'b0, 1'b1, 1'b0, 1'b1, 18'h11111, 18'h0C3C3, 1'b0},
    '{1'b1, 1'b0, 1'b1, 1'b0, 18'h00001, 18'h00001, 1'b1},
    '{1'b1, 1'b1, 1'b1, 1'b1, 18'h3FFFF, 18'h3FFFF, 1'b0},
    '{1'b0, 1'b0, 1'b1, 1'b1, 18'h12345, 18'h12345, 1'b0},
    '{1'b0, 1'b0, 1'b0, 1'b1, 18'h00000, 18'h12345, 1'b0},
    '{1'b1, 1'b0, 1'b0, 1'b0, 18'h20000, 18'h20000, 1'b1},
    '{1'b0, 1'b1, 1'b0, 1'b0, 18'h0FFFF, 18'h20000, 1'b1},
    '{1'b1, 1'b0, 1'b0, 1'b1, 18'h3FFFF, 18'h3FFFF, 1'b0},
    '{1'b0, 1'b1, 1'b1, 1'b1, 18'h00000, 18'h3FFFF, 1'b0},
    '{1'b1, 1'b1, 1'b0, 1'b1, 18'h2468A, 18'h2468A, 1'b0},
    '{1'b1, 1'b0, 1'b1, 1'b1, 18'h13579, 18'h13579, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b0, 18'h00000, 18'h00000, 1'b1}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         ab_le = 1'b0, ab_dclk = 1'b0, ab_ce_n = 1'b1, ab_oe_n = 1'b1;
  logic         ba_le = 1'b0, ba_dclk = 1'b0, ba_ce_n = 1'b1, ba_oe_n = 1'b1;
  logic [W-1:0] b_out, a_out;
  logic         b_drive, a_drive;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  dual_path_bus_reg #(.W(W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .ab_le(ab_le), .ab_dclk(ab_dclk), .ab_ce_n(ab_ce_n), .ab_oe_n(ab_oe_n),
    .ba_le(ba_le), .ba_dclk(ba_dclk), .ba_ce_n(ba_ce_n), .ba_oe_n(ba_oe_n),
    .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive)
  );

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic settle();
    repeat (LAT + 1) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive_dir(input int dir, input logic le, input logic ce_n,
                           input logic dclk, input logic oe_n, input logic [W-1:0] d);
    if (dir == 0) begin
      ab_le = le; ab_ce_n = ce_n; ab_dclk = dclk; ab_oe_n = oe_n; a_in = d;
    end else begin
      ba_le = le; ba_ce_n = ce_n; ba_dclk = dclk; ba_oe_n = oe_n; b_in = d;
    end
  endtask

  task automatic set_clk(input int dir, input logic v);
    if (dir == 0) ab_dclk = v; else ba_dclk = v;
  endtask

  task automatic run_table(input int dir);
    for (int i = 0; i < 16; i++) begin
      drive_dir(dir, TABLE[i].le, TABLE[i].ce_n, 1'b0, TABLE[i].oe_n, TABLE[i].din);
      settle();
      if (TABLE[i].pulse) begin
        set_clk(dir, 1'b1);
        settle();
        set_clk(dir, 1'b0);
        settle();
      end
      if (dir == 0) begin
        check($sformatf("R1-R4 table word ab vec %0d", i), b_out, TABLE[i].exp_q);
        check($sformatf("R5 table drive ab vec %0d", i), W'(b_drive), W'(TABLE[i].exp_drv));
      end else begin
        check($sformatf("R1-R4 table word ba vec %0d", i), a_out, TABLE[i].exp_q);
        check($sformatf("R5 table drive ba vec %0d", i), W'(a_drive), W'(TABLE[i].exp_drv));
      end
    end
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog expired got=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R8: state right after reset
    check("R8 reset b_out", b_out, '0);
    check("R8 reset a_out", a_out, '0);
    check("R8 reset drives", W'({a_drive, b_drive}), '0);
    rst = 1'b0;
    settle();

    // R9: pass-through latency of LAT edges
    ab_le = 1'b1; a_in = 18'h2BEEF;
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk);
    check("R9 one edge early still old", b_out, '0);
    @(posedge clk);
    @(negedge clk);
    check("R9 new word on edge LAT", b_out, 18'h2BEEF);
    ab_le = 1'b0;
    settle();

    // R1-R5: table for A-to-B (B-to-A undriven)
    run_table(0);
    drive_dir(0, 1'b0, 1'b1, 1'b0, 1'b1, '0);
    settle();

    // R7: latch closes while data clock is high
    drive_dir(0, 1'b1, 1'b0, 1'b1, 1'b1, 18'h2C3C3);
    settle();
    ab_le = 1'b0; a_in = 18'h01234;
    settle();
    check("R7 closed with clock high keeps passed word", b_out, 18'h2C3C3);
    ab_dclk = 1'b0;
    settle();
    check("R7 falling data clock loads nothing", b_out, 18'h2C3C3);
    ab_ce_n = 1'b1; ab_dclk = 1'b1;
    settle();
    check("R4 gated rising edge ignored", b_out, 18'h2C3C3);
    ab_dclk = 1'b0; ab_ce_n = 1'b0;
    settle();
    ab_dclk = 1'b1;
    settle();
    check("R3 enabled rising edge loads", b_out, 18'h01234);
    ab_dclk = 1'b0;
    a_in = 18'h3ABCD;
    settle();
    check("R2 input change ignored while closed", b_out, 18'h01234);

    // R6: load A-to-B, then exercise B-to-A only
    drive_dir(0, 1'b1, 1'b1, 1'b0, 1'b1, 18'h1F0F0);
    settle();
    ab_le = 1'b0;
    settle();
    run_table(1);
    check("R6 A-to-B word untouched by B-to-A", b_out, 18'h1F0F0);
    check("R6 A-to-B flag untouched", W'(b_drive), '0);
    drive_dir(1, 1'b0, 1'b1, 1'b0, 1'b1, '0);
    settle();

    // R10: one output enable active, the other idle
    ab_oe_n = 1'b0;
    settle();
    check("R10 own enable raises own flag", W'(b_drive), W'(1));
    check("R10 other flag stays low", W'(a_drive), '0);
    check("R5 undriven word still visible", a_out, 18'h00000);

    // R8: reset during operation
    ba_le = 1'b1; b_in = 18'h0ACE1;
    settle();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8 mid-run reset b_out", b_out, '0);
    check("R8 mid-run reset a_out", a_out, '0);
    check("R8 mid-run reset flag", W'(b_drive), '0);
    ba_le = 1'b0;
    repeat (LAT + 1) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    settle();
    check("R8 word stays clear after release", a_out, '0);
    check("R5 flag returns after release", W'(b_drive), W'(1));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule